// File: doc/BRIEF.md
# Sampled Supply Monitor Controller

This block is the slow-clock control logic that surrounds an analog supply comparator. It decides when the comparator is powered. The comparator can run all the time, or it can be enabled for one slow-clock period in every 32, 256 or 2048 periods. It passes a 4-bit threshold code to the analog side. The comparator output is modelled as a single digital input, where 1 means the supply is below the threshold.

Each sampled result is stored as a live status bit. A detection also sets a sticky event bit, which stays set until software reads the status register. The detection is routed to three outputs, each with its own enable: a level interrupt, a single-cycle core reset request and a single-cycle wake-up request. Software reaches the configuration through a small synchronous register port with registered read data.

Top module: `supmon_ctrl`

## Requirements
- R1: After a synchronous reset, all of these read as zero: every register, `rdata`, `cmp_en`, `thresh_code`, `irq`, `core_rst_req` and `wake_req`.
- R2: `thresh_code` equals bits [3:0] of the config register (address 0) from the cycle after that register is written. Code 0 selects the lowest threshold and code 15 the highest, in 16 equal steps.
- R3: Sampling mode code 1 (config bits [6:4]) is continuous: `cmp_en` is high in every cycle, starting in the second cycle after the mode is written.
- R4: Mode codes 2, 3 and 4 give periodic sampling. `cmp_en` is high for exactly one cycle in every 32, 256 or 2048 cycles. The first window comes N cycles after the first cycle in the new mode.
- R5: Mode codes 0, 5, 6 and 7 disable the monitor. `cmp_en` stays low and no detection occurs.
- R6: The live status bit (status register address 3, bit 0) takes the value of `cmp_in` at the clock edge that ends a cycle with `cmp_en` high. At all other times it holds.
- R7: A detection is `cmp_in` high in a cycle with `cmp_en` high. It sets the sticky bit (status bit 1). A read of address 3 returns the bit as it was and then clears it, unless a detection occurs in the same cycle as the read. In that case the bit stays set.
- R8: `irq` is high whenever the sticky bit is set and the interrupt enable (control register address 1, bit 1) is set.
- R9: When the reset enable (control bit 0) is set, each detection produces `core_rst_req` high for the one cycle that follows it.
- R10: When the wake-up enable (wake-up register address 2, bit 0) is set, each detection produces `wake_req` high for the one cycle that follows it.
- R11: A read (`rd_en` high) puts the addressed register on `rdata` in the next cycle. Unused bits read as zero, and `rdata` holds between reads. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| cmp_in | input | 1 | Comparator output, 1 = supply below threshold |
| cmp_en | output | 1 | Comparator power enable |
| thresh_code | output | 4 | Threshold code to the comparator |
| irq | output | 1 | Supply monitor interrupt |
| core_rst_req | output | 1 | Core reset request pulse |
| wake_req | output | 1 | Core wake-up request pulse |

## Verification
A detection is taken at the edge that closes a cycle with `cmp_en` high. The live bit, the sticky bit, `irq` and both request pulses are therefore due in the cycle right after that edge. `rdata` and `thresh_code` follow one cycle after their strobe. `cmp_en` follows the mode write after a one-cycle restart and the counter delay given in R3 and R4.

The bench steps a cycle-level model on the same edge as the design and compares every output at the falling edge. Because of this, each result is compared in exactly the cycle the requirements place it. The bench also checks the same-cycle read-and-detect case directly.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int THR_W  = 4;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTL  = 2'd1;
  localparam logic [ADDR_W-1:0] A_WAKE = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  localparam logic [MODE_W-1:0] M_OFF   = 3'd0;
  localparam logic [MODE_W-1:0] M_CONT  = 3'd1;
  localparam logic [MODE_W-1:0] M_PER0  = 3'd2;
  localparam logic [MODE_W-1:0] M_PER1  = 3'd3;
  localparam logic [MODE_W-1:0] M_PER2  = 3'd4;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [THR_W-1:0]  thr;
  } cfg_t;

  typedef struct packed {
    logic irq_en;
    logic rst_en;
  } ctl_t;
endpackage

// File: rtl/supmon_sampler.sv
module supmon_sampler
  import supmon_pkg::*;
#(
  parameter int LOG_P0 = 5,
  parameter int LOG_P1 = 8,
  parameter int LOG_P2 = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  output logic              cmp_en
);
  localparam int CNT_W = LOG_P2 + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last;
  logic [MODE_W-1:0] mode_q;
  logic              periodic;
  logic              en_q;

  // Last count value of the active period; zero when not periodic.
  always_comb begin
    periodic = 1'b1;
    unique case (mode)
      M_PER0:  last = CNT_W'((1 << LOG_P0) - 1);
      M_PER1:  last = CNT_W'((1 << LOG_P1) - 1);
      M_PER2:  last = CNT_W'((1 << LOG_P2) - 1);
      default: begin
        last     = '0;
        periodic = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      en_q   <= 1'b0;
      mode_q <= M_OFF;
    end else begin
      mode_q <= mode;
      if (mode != mode_q) begin
        // restart the phase on any mode change
        cnt_q <= '0;
        en_q  <= 1'b0;
      end else if (mode == M_CONT) begin
        cnt_q <= '0;
        en_q  <= 1'b1;
      end else if (periodic) begin
        cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
        en_q  <= (cnt_q == last - 1'b1);
      end else begin
        cnt_q <= '0;
        en_q  <= 1'b0;
      end
    end
  end

  assign cmp_en = en_q;
endmodule

// File: rtl/supmon_event.sv
module supmon_event (
  input  logic clk,
  input  logic rst,
  input  logic cmp_en,
  input  logic cmp_in,
  input  logic rd_clr,
  input  logic irq_en,
  input  logic rst_en,
  input  logic wake_en,
  output logic live,
  output logic sticky,
  output logic irq,
  output logic core_rst_req,
  output logic wake_req
);
  localparam int NREQ = 2;

  logic            det;
  logic            sticky_d;
  logic            live_q, sticky_q, irq_q;
  logic [NREQ-1:0] req_en;
  logic [NREQ-1:0] req_q;

  assign det      = cmp_en & cmp_in;
  assign sticky_d = det | (sticky_q & ~rd_clr);
  assign req_en   = {wake_en, rst_en};

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= 1'b0;
      sticky_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (cmp_en) live_q <= cmp_in;
      sticky_q <= sticky_d;
      irq_q    <= sticky_d & irq_en;
    end
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst) req_q[g] <= 1'b0;
      else     req_q[g] <= det & req_en[g];
    end
  end

  assign live         = live_q;
  assign sticky       = sticky_q;
  assign irq          = irq_q;
  assign core_rst_req = req_q[0];
  assign wake_req     = req_q[1];
endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              live,
  input  logic              sticky,
  output logic [THR_W-1:0]  thr,
  output logic [MODE_W-1:0] mode,
  output logic              irq_en,
  output logic              rst_en,
  output logic              wake_en,
  output logic              rd_clr,
  output logic [DATA_W-1:0] rdata
);
  localparam int CFG_W = THR_W + MODE_W;

  cfg_t              cfg_q;
  ctl_t              ctl_q;
  logic              wake_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_bits;

  assign unused_bits = ^wdata[DATA_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      ctl_q  <= '0;
      wake_q <= 1'b0;
    end else if (wr_en) begin
      unique case (addr)
        A_CFG:   cfg_q  <= cfg_t'(wdata[CFG_W-1:0]);
        A_CTL:   ctl_q  <= ctl_t'(wdata[1:0]);
        A_WAKE:  wake_q <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      A_CFG:   rd_mux = DATA_W'(cfg_q);
      A_CTL:   rd_mux = DATA_W'(ctl_q);
      A_WAKE:  rd_mux = DATA_W'(wake_q);
      default: rd_mux = DATA_W'({sticky, live});
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign thr     = cfg_q.thr;
  assign mode    = cfg_q.mode;
  assign irq_en  = ctl_q.irq_en;
  assign rst_en  = ctl_q.rst_en;
  assign wake_en = wake_q;
  assign rd_clr  = rd_en && (addr == A_STAT);
  assign rdata   = rdata_q;
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOG_P0 = 5,
  parameter int LOG_P1 = 8,
  parameter int LOG_P2 = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cmp_in,
  output logic              cmp_en,
  output logic [3:0]        thresh_code,
  output logic              irq,
  output logic              core_rst_req,
  output logic              wake_req
);
  logic [MODE_W-1:0] cfg_mode;
  logic              irq_en, rst_en, wake_en, rd_clr;
  logic              live, sticky;

  supmon_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .live(live), .sticky(sticky), .thr(thresh_code),
    .mode(cfg_mode), .irq_en(irq_en), .rst_en(rst_en), .wake_en(wake_en),
    .rd_clr(rd_clr), .rdata(rdata)
  );

  supmon_sampler #(.LOG_P0(LOG_P0), .LOG_P1(LOG_P1), .LOG_P2(LOG_P2)) u_samp (
    .clk(clk), .rst(rst), .mode(cfg_mode), .cmp_en(cmp_en)
  );

  supmon_event u_evt (
    .clk(clk), .rst(rst), .cmp_en(cmp_en), .cmp_in(cmp_in), .rd_clr(rd_clr),
    .irq_en(irq_en), .rst_en(rst_en), .wake_en(wake_en), .live(live),
    .sticky(sticky), .irq(irq), .core_rst_req(core_rst_req),
    .wake_req(wake_req)
  );
endmodule

// File: rtl/supmon_chk.sv
module supmon_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic       cmp_en,
  input logic       cmp_in,
  input logic       sticky,
  input logic       irq,
  input logic       core_rst_req,
  input logic       wake_req,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [3:0] thr_wdata,
  input logic [3:0] thresh_code
);
  p_thr_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(addr) == 2'd0)
      |-> thresh_code == $past(thr_wdata));

  p_cont_en_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd1 && $past(mode) == 3'd1 && $past(mode, 2) == 3'd1) |-> cmp_en);

  p_single_window_r4: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && mode >= 3'd2 && mode <= 3'd4) |=> !cmp_en);

  p_off_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 || mode >= 3'd5) |=> !cmp_en);

  p_sticky_set_r7: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && cmp_in) |=> sticky);

  p_irq_needs_event_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> sticky);

  p_rst_cause_r9: assert property (@(posedge clk) disable iff (rst)
    core_rst_req |-> $past(cmp_en && cmp_in));

  p_wake_cause_r10: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(cmp_en && cmp_in));
endmodule

bind supmon_ctrl supmon_chk u_chk (
  .clk(clk), .rst(rst), .mode(cfg_mode), .cmp_en(cmp_en), .cmp_in(cmp_in),
  .sticky(sticky), .irq(irq), .core_rst_req(core_rst_req),
  .wake_req(wake_req), .wr_en(wr_en), .addr(addr), .thr_wdata(wdata[3:0]),
  .thresh_code(thresh_code)
);

// File: tb/tb_supmon_ctrl.sv
module tb_supmon_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, cmp_in = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       cmp_en, irq, core_rst_req, wake_req;
  logic [3:0] thresh_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  supmon_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cmp_in(cmp_in), .cmp_en(cmp_en),
    .thresh_code(thresh_code), .irq(irq), .core_rst_req(core_rst_req),
    .wake_req(wake_req)
  );

  // ---------------- reference model ----------------
  logic [6:0]  m_cfg;
  logic [1:0]  m_ctl;
  logic        m_wake, m_en, m_live, m_sticky, m_irq, m_rst, m_wk;
  logic [2:0]  m_modeq;
  int          m_cnt;
  logic [7:0]  m_rdata;
  logic        m_stat_rd;

  function automatic int period_of(input logic [2:0] md);
    case (md)
      3'd1:    return 1;
      3'd2:    return 32;
      3'd3:    return 256;
      3'd4:    return 2048;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] read_val(input logic [1:0] a);
    case (a)
      2'd0:    return {1'b0, m_cfg};
      2'd1:    return {6'd0, m_ctl};
      2'd2:    return {7'd0, m_wake};
      default: return {6'd0, m_sticky, m_live};
    endcase
  endfunction

  always @(posedge clk) begin
    logic [2:0] md;
    int n, cnt_n;
    logic en_n, det, st_n;
    if (rst) begin
      m_cfg = '0; m_ctl = '0; m_wake = 0; m_en = 0; m_live = 0;
      m_sticky = 0; m_irq = 0; m_rst = 0; m_wk = 0; m_modeq = 0;
      m_cnt = 0; m_rdata = 0; m_stat_rd = 0;
    end else begin
      md = m_cfg[6:4];
      n  = period_of(md);
      if (md != m_modeq || n == 0) begin cnt_n = 0; en_n = 0; end
      else if (n == 1) begin cnt_n = 0; en_n = 1; end
      else begin
        cnt_n = (m_cnt == n - 1) ? 0 : m_cnt + 1;
        en_n  = (m_cnt == n - 2);
      end
      det  = m_en & cmp_in;
      st_n = det | (m_sticky & ~(rd_en && addr == 2'd3));
      if (rd_en) m_rdata = read_val(addr);
      m_stat_rd = rd_en && addr == 2'd3;
      if (m_en) m_live = cmp_in;
      m_sticky = st_n;
      m_irq = st_n & m_ctl[1];
      m_rst = det & m_ctl[0];
      m_wk  = det & m_wake;
      if (wr_en) begin
        case (addr)
          2'd0: m_cfg = wdata[6:0];
          2'd1: m_ctl = wdata[1:0];
          2'd2: m_wake = wdata[0];
          default: ;
        endcase
      end
      m_modeq = md;
      m_cnt = cnt_n;
      m_en = en_n;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [2:0] md;
    md = m_cfg[6:4];
    if (md == 3'd1)                     chk("R3", "cmp_en", cmp_en, m_en);
    else if (md >= 3'd2 && md <= 3'd4)  chk("R4", "cmp_en", cmp_en, m_en);
    else                                chk("R5", "cmp_en", cmp_en, m_en);
    chk("R2",  "thresh_code", thresh_code, m_cfg[3:0]);
    chk("R8",  "irq", irq, m_irq);
    chk("R9",  "core_rst_req", core_rst_req, m_rst);
    chk("R10", "wake_req", wake_req, m_wk);
    chk("R11", "rdata", rdata, m_rdata);
    if (m_stat_rd) begin
      chk("R6", "status live bit", rdata[0], m_rdata[0]);
      chk("R7", "status sticky bit", rdata[1], m_rdata[1]);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [1:0] a,
                      input logic [7:0] d, input logic c);
    wr_en = w; rd_en = r; addr = a; wdata = d; cmp_in = c;
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) step(0, 0, 2'd0, 8'd0, 0);
  endtask

  task automatic run_random(input int cyc, input int pct_hi);
    for (int i = 0; i < cyc; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 10)      step(0, 1, 2'd3, 8'd0, ($urandom_range(0, 99) < pct_hi));
      else if (r < 13) step(0, 1, 2'($urandom_range(0, 2)), 8'd0, ($urandom_range(0, 99) < pct_hi));
      else if (r < 15) step(1, 0, 2'd1, 8'($urandom), ($urandom_range(0, 99) < pct_hi));
      else if (r < 17) step(1, 0, 2'd2, 8'($urandom), ($urandom_range(0, 99) < pct_hi));
      else if (r < 18) step(1, 0, 2'd3, 8'($urandom), ($urandom_range(0, 99) < pct_hi));
      else             step(0, 0, 2'd0, 8'd0, ($urandom_range(0, 99) < pct_hi));
    end
  endtask

  task automatic set_mode(input logic [2:0] md, input logic [3:0] thr);
    step(1, 0, 2'd0, {1'b0, md, thr}, 0);
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state on every output and register
    chk("R1", "cmp_en after reset", cmp_en, 0);
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "thresh_code after reset", thresh_code, 0);
    chk("R1", "core_rst_req after reset", core_rst_req, 0);
    chk("R1", "wake_req after reset", wake_req, 0);
    chk("R1", "rdata after reset", rdata, 0);
    for (int a = 0; a < 4; a++) begin
      step(0, 1, 2'(a), 8'd0, 0);
      chk("R1", "register read after reset", rdata, 0);
    end

    // R2: threshold extremes
    set_mode(3'd0, 4'd15);
    idle(1);
    chk("R2", "top threshold code", thresh_code, 15);
    set_mode(3'd0, 4'd0);
    idle(1);

    // enable all outputs
    step(1, 0, 2'd1, 8'h03, 0);
    step(1, 0, 2'd2, 8'h01, 0);

    // R3: continuous, then directed same-cycle read and detection (R7)
    set_mode(3'd1, 4'd7);
    idle(3);
    chk("R3", "continuous enable", cmp_en, 1);
    step(0, 1, 2'd3, 8'd0, 1);
    step(0, 1, 2'd3, 8'd0, 0);
    chk("R7", "sticky kept on read with detection", rdata[1], 1);
    step(0, 1, 2'd3, 8'd0, 0);
    chk("R7", "sticky cleared by read", rdata[1], 0);
    run_random(400, 30);

    // R4: periodic modes
    set_mode(3'd2, 4'd3);
    run_random(500, 40);
    set_mode(3'd3, 4'd9);
    run_random(1200, 40);
    set_mode(3'd4, 4'd12);
    run_random(4500, 50);

    // R5: disabled codes with comparator held high
    for (int m = 0; m < 8; m++) begin
      if (m == 0 || m >= 5) begin
        set_mode(3'(m), 4'(m));
        run_random(150, 100);
      end
    end

    // back to periodic with random traffic, then continuous again
    set_mode(3'd2, 4'd5);
    run_random(600, 50);
    set_mode(3'd1, 4'd1);
    run_random(300, 20);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule